// File: doc/BRIEF.md
# ATM OAM Cell Formatter

This block sits in a cell transmit path and turns a plain 53-octet ATM cell into an operations-and-maintenance cell as it streams through. Octets arrive one per cycle on a valid/ready input with a start-of-cell marker. They leave on a valid/ready output with start and end markers. There is no storage on the data path, so an octet leaves in the same cycle it is accepted.

A command word travels alongside the first octet of each cell. It can replace the VCI and the PTI fields of the UNI header. This is how F4 cells are made (VCI 3 for segment, VCI 4 for end-to-end) and how F5 cells are made (PTI 3'b100 for segment, 3'b101 for end-to-end). The command can also ask for a CRC-10 error detection code over the information field, placed in the last ten payload bits.

Back-pressure rule: inside a cell, `in_ready` follows `out_ready` directly. A stalled output therefore stalls the input, and the running CRC advances only on accepted octets. Between cells, octets that lack a start marker are accepted and dropped.

Top module: `oam_cell_fmt`

## Requirements
- R1: A cell begins with an accepted octet that carries `in_sop` while the block is idle, and lasts exactly 53 accepted octets. `out_sop` marks the first output octet of the cell and `out_eop` marks the 53rd.
- R2: While idle, an octet offered without `in_sop` is accepted (`in_ready`=1) and dropped (`out_valid`=0).
- R3: Inside a cell, `out_valid` equals `in_valid`, `in_ready` equals `out_ready`, and the output octet appears in the same cycle as the input octet.
- R4: The command inputs are sampled with the first octet of a cell and govern the whole cell. Later changes on those pins have no effect until the next cell.
- R5: When `cmd_hdr_mod` and `cmd_wr_vci` are both 1, VCI[15:12] replaces bits 3:0 of header octet 2, VCI[11:4] replaces header octet 3, and VCI[3:0] replaces bits 7:4 of header octet 4 (octets counted from 1).
- R6: When `cmd_hdr_mod` and `cmd_wr_pti` are both 1, the 3-bit PTI replaces bits 3:1 of header octet 4.
- R7: Header octet 1, bits 7:4 of octet 2, bit 0 of octet 4 (CLP) and octet 5 always pass unchanged. With `cmd_hdr_mod` at 0, the whole header passes unchanged whatever the two write enables say.
- R8: With `cmd_crc_en` at 1, a CRC-10 with polynomial x^10+x^9+x^5+x^4+x+1 and a zero start value is run MSB first over payload octets 1 to 46 and then six zero bits. Payload octet 47 leaves as {6'b0, crc[9:8]} and payload octet 48 leaves as crc[7:0]. An all-zero payload gives a code of zero.
- R9: With `cmd_crc_en` at 0, all 48 payload octets pass unchanged.
- R10: Output stalls of any length inside a cell change neither the CRC nor any octet of the cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input octet valid |
| in_ready | output | 1 | Input octet accepted when high with in_valid |
| in_data | input | 8 | Input octet |
| in_sop | input | 1 | Marks the first octet of a cell |
| cmd_crc_en | input | 1 | Insert CRC-10 into the last ten payload bits |
| cmd_hdr_mod | input | 1 | Master enable for header rewrites |
| cmd_wr_pti | input | 1 | Rewrite PTI (needs cmd_hdr_mod) |
| cmd_wr_vci | input | 1 | Rewrite VCI (needs cmd_hdr_mod) |
| cmd_pti | input | 3 | Replacement PTI |
| cmd_vci | input | 16 | Replacement VCI |
| out_valid | output | 1 | Output octet valid |
| out_ready | input | 1 | Downstream accepts the output octet |
| out_data | output | 8 | Output octet |
| out_sop | output | 1 | First octet of the output cell |
| out_eop | output | 1 | Last octet of the output cell |

## Verification
Two things can fall on the same cycle. One is a downstream stall on one of the last two payload octets, where the CRC tail is being folded and emitted. The other is a change on the command pins while the cell is in progress. The table-driven cells hold `out_ready` low on a pseudo-random pattern, and every cell drives inverted command values once its first octet is accepted. Each output octet is compared with a bit-serial reference code and a header rewrite computed in the bench. A stall that corrupted the CRC, or a command that leaked into the cell, shows up as a mismatch on octet 4 or on the final two octets.

// File: rtl/oam_fmt_pkg.sv
package oam_fmt_pkg;
  localparam int OCT_W    = 8;
  localparam int CRC_W    = 10;
  localparam logic [CRC_W-1:0] CRC_POLY = 10'h233;
  localparam int PAD_BITS = 6;

  typedef struct packed {
    logic        crc_en;
    logic        hdr_mod;
    logic        wr_pti;
    logic        wr_vci;
    logic [2:0]  pti;
    logic [15:0] vci;
  } oam_cmd_t;

  function automatic logic [CRC_W-1:0] crc10_step(input logic [CRC_W-1:0] c, input logic b);
    logic fb;
    fb = c[CRC_W-1] ^ b;
    return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  endfunction

  function automatic logic [CRC_W-1:0] crc10_octet(input logic [CRC_W-1:0] c,
                                                   input logic [OCT_W-1:0] d);
    logic [CRC_W-1:0] r;
    r = c;
    for (int i = OCT_W-1; i >= 0; i--) r = crc10_step(r, d[i]);
    return r;
  endfunction

  function automatic logic [CRC_W-1:0] crc10_pad(input logic [CRC_W-1:0] c);
    logic [CRC_W-1:0] r;
    r = c;
    for (int i = 0; i < PAD_BITS; i++) r = crc10_step(r, 1'b0);
    return r;
  endfunction
endpackage

// File: rtl/oam_pos_track.sv
module oam_pos_track #(
  parameter int CELL_LEN = 53,
  localparam int POS_W   = $clog2(CELL_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic             sop,
  output logic [POS_W-1:0] pos,
  output logic             in_cell,
  output logic             first,
  output logic             last
);
  logic [POS_W-1:0] pos_q;

  assign pos     = pos_q;
  assign first   = (pos_q == '0);
  assign last    = (pos_q == POS_W'(CELL_LEN-1));
  assign in_cell = !first || sop;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q <= '0;
    end else if (fire && in_cell) begin
      pos_q <= last ? '0 : pos_q + 1'b1;
    end
  end
endmodule

// File: rtl/oam_hdr_patch.sv
module oam_hdr_patch
  import oam_fmt_pkg::*;
#(
  parameter int CELL_LEN = 53,
  localparam int POS_W   = $clog2(CELL_LEN)
) (
  input  logic [POS_W-1:0] pos,
  input  logic [7:0]       din,
  input  oam_cmd_t         cmd,
  output logic [7:0]       dout
);
  logic put_vci, put_pti;

  assign put_vci = cmd.hdr_mod && cmd.wr_vci;
  assign put_pti = cmd.hdr_mod && cmd.wr_pti;

  always_comb begin
    dout = din;
    unique case (pos)
      POS_W'(1): if (put_vci) dout[3:0] = cmd.vci[15:12];
      POS_W'(2): if (put_vci) dout      = cmd.vci[11:4];
      POS_W'(3): begin
        if (put_vci) dout[7:4] = cmd.vci[3:0];
        if (put_pti) dout[3:1] = cmd.pti;
      end
      default: dout = din;
    endcase
  end
endmodule

// File: rtl/oam_crc10_unit.sv
module oam_crc10_unit
  import oam_fmt_pkg::*;
#(
  parameter int CELL_LEN = 53,
  parameter int HDR_LEN  = 5,
  localparam int POS_W   = $clog2(CELL_LEN),
  localparam int TAIL_HI = CELL_LEN - 2,
  localparam int TAIL_LO = CELL_LEN - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic [POS_W-1:0] pos,
  input  logic             crc_en,
  input  logic [7:0]       din,
  output logic [7:0]       dout
);
  logic [CRC_W-1:0] crc_q, base, folded;
  logic             in_body;

  assign base    = (pos == POS_W'(HDR_LEN)) ? '0 : crc_q;
  assign folded  = crc10_pad(crc_q);
  assign in_body = (pos >= POS_W'(HDR_LEN)) && (pos < POS_W'(TAIL_HI));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crc_q <= '0;
    end else if (fire) begin
      if (in_body)                        crc_q <= crc10_octet(base, din);
      else if (pos == POS_W'(TAIL_HI))    crc_q <= folded;
    end
  end

  always_comb begin
    dout = din;
    if (crc_en) begin
      if (pos == POS_W'(TAIL_HI))      dout = {6'b0, folded[9:8]};
      else if (pos == POS_W'(TAIL_LO)) dout = crc_q[7:0];
    end
  end
endmodule

// File: rtl/oam_cell_fmt.sv
module oam_cell_fmt
  import oam_fmt_pkg::*;
#(
  parameter int CELL_LEN = 53,
  parameter int HDR_LEN  = 5,
  localparam int POS_W   = $clog2(CELL_LEN)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_data,
  input  logic        in_sop,
  input  logic        cmd_crc_en,
  input  logic        cmd_hdr_mod,
  input  logic        cmd_wr_pti,
  input  logic        cmd_wr_vci,
  input  logic [2:0]  cmd_pti,
  input  logic [15:0] cmd_vci,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [7:0]  out_data,
  output logic        out_sop,
  output logic        out_eop
);
  logic [POS_W-1:0] pos;
  logic             in_cell, first, last, fire;
  oam_cmd_t         cmd_pin, cmd_q, cmd_eff;
  logic [7:0]       hdr_byte, pay_byte;
  logic             eff_crc, eff_hdr;

  assign cmd_pin = '{crc_en: cmd_crc_en, hdr_mod: cmd_hdr_mod, wr_pti: cmd_wr_pti,
                     wr_vci: cmd_wr_vci, pti: cmd_pti, vci: cmd_vci};

  assign in_ready  = in_cell ? out_ready : 1'b1;
  assign out_valid = in_valid && in_cell;
  assign fire      = in_valid && in_ready;

  oam_pos_track #(.CELL_LEN(CELL_LEN)) u_pos (
    .clk(clk), .rst_n(rst_n), .fire(fire), .sop(in_sop),
    .pos(pos), .in_cell(in_cell), .first(first), .last(last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) cmd_q <= '0;
    else if (fire && first && in_sop) cmd_q <= cmd_pin;
  end

  assign cmd_eff = first ? cmd_pin : cmd_q;
  assign eff_crc = cmd_eff.crc_en;
  assign eff_hdr = cmd_eff.hdr_mod;

  oam_hdr_patch #(.CELL_LEN(CELL_LEN)) u_hdr (
    .pos(pos), .din(in_data), .cmd(cmd_eff), .dout(hdr_byte)
  );

  oam_crc10_unit #(.CELL_LEN(CELL_LEN), .HDR_LEN(HDR_LEN)) u_crc (
    .clk(clk), .rst_n(rst_n), .fire(fire), .pos(pos),
    .crc_en(eff_crc), .din(in_data), .dout(pay_byte)
  );

  assign out_data = (pos < POS_W'(HDR_LEN)) ? hdr_byte : pay_byte;
  assign out_sop  = out_valid && first;
  assign out_eop  = out_valid && last;
endmodule

// File: rtl/oam_cell_fmt_chk.sv
module oam_cell_fmt_chk #(
  parameter int CELL_LEN = 53
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic [7:0] in_data,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_sop,
  input logic       out_eop,
  input logic       eff_crc,
  input logic       eff_hdr
);
  logic [6:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (out_valid && out_ready) cnt <= out_eop ? '0 : cnt + 1'b1;
  end

  p_sop_pos_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_sop == (cnt == 7'd0)));
  p_eop_pos_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_eop == (cnt == 7'(CELL_LEN-1))));
  p_no_phantom_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_valid);
  p_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
  p_first_hdr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (cnt == 7'd0 || cnt == 7'd4)) |-> (out_data == in_data));
  p_hdr_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !eff_hdr && cnt < 7'd5) |-> (out_data == in_data));
  p_plain_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !eff_crc && cnt >= 7'd5) |-> (out_data == in_data));
  p_pad_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && eff_crc && cnt == 7'(CELL_LEN-2)) |-> (out_data[7:2] == 6'b0));
endmodule

bind oam_cell_fmt oam_cell_fmt_chk #(.CELL_LEN(CELL_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop),
  .eff_crc(eff_crc), .eff_hdr(eff_hdr)
);

// File: tb/oam_cell_fmt_bench.sv
module oam_cell_fmt_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_sop = 1'b0, out_ready = 1'b1;
  logic [7:0]  in_data = '0;
  logic        cmd_crc_en = 1'b0, cmd_hdr_mod = 1'b0, cmd_wr_pti = 1'b0, cmd_wr_vci = 1'b0;
  logic [2:0]  cmd_pti = '0;
  logic [15:0] cmd_vci = '0;
  logic        in_ready, out_valid, out_sop, out_eop;
  logic [7:0]  out_data;

  int n_cmp = 0, n_bad = 0;
  int unsigned rng = 32'h1234_5678;

  always #2 clk = ~clk;

  oam_cell_fmt u_oam_cell_fmt (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sop(in_sop), .cmd_crc_en(cmd_crc_en),
    .cmd_hdr_mod(cmd_hdr_mod), .cmd_wr_pti(cmd_wr_pti), .cmd_wr_vci(cmd_wr_vci),
    .cmd_pti(cmd_pti), .cmd_vci(cmd_vci), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop)
  );

  // {crc_en, hdr_mod, wr_pti, wr_vci, pti[2:0], vci[15:0], seed[7:0], stall}
  localparam logic [31:0] VEC [8] = '{
    {1'b1, 1'b1, 1'b0, 1'b1, 3'b000, 16'd3,      8'h11, 1'b0},
    {1'b1, 1'b1, 1'b0, 1'b1, 3'b000, 16'd4,      8'h5A, 1'b1},
    {1'b1, 1'b1, 1'b1, 1'b0, 3'b100, 16'hFFFF,   8'h93, 1'b0},
    {1'b1, 1'b1, 1'b1, 1'b0, 3'b101, 16'h0000,   8'hC7, 1'b1},
    {1'b0, 1'b1, 1'b1, 1'b1, 3'b101, 16'd3,      8'h2E, 1'b1},
    {1'b1, 1'b0, 1'b1, 1'b1, 3'b111, 16'hABCD,   8'h64, 1'b0},
    {1'b0, 1'b0, 1'b0, 1'b0, 3'b010, 16'h1234,   8'hF0, 1'b1},
    {1'b1, 1'b1, 1'b1, 1'b1, 3'b100, 16'd4,      8'h3B, 1'b1}
  };

  logic [7:0] cell_in  [53];
  logic [7:0] cell_exp [53];
  logic [7:0] cell_out [53];

  function automatic int unsigned next_rng(input int unsigned s);
    return s * 32'd1664525 + 32'd1013904223;
  endfunction

  function automatic logic [9:0] ref_crc(input logic [7:0] pay [53]);
    logic [9:0] c = '0;
    logic fb;
    for (int i = 0; i < 46 * 8 + 6; i++) begin
      logic b;
      b = (i < 46 * 8) ? pay[5 + i / 8][7 - (i % 8)] : 1'b0;
      fb = c[9] ^ b;
      c = {c[8:0], 1'b0};
      if (fb) c = c ^ 10'b10_0011_0011;
    end
    return c;
  endfunction

  task automatic check(input string req, input int idx, input logic [7:0] got, input logic [7:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s octet %0d: actual %02h expected %02h", req, idx, got, exp);
    end
  endtask

  task automatic check_bit(input string req, input logic got, input logic exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b", req, got, exp);
    end
  endtask

  task automatic build_expect(input logic [31:0] v);
    logic [9:0] c;
    for (int i = 0; i < 53; i++) cell_exp[i] = cell_in[i];
    if (v[30] && v[28]) begin
      cell_exp[1][3:0] = v[24:21];
      cell_exp[2]      = v[20:13];
      cell_exp[3][7:4] = v[12:9];
    end
    if (v[30] && v[29]) cell_exp[3][3:1] = v[27:25];
    if (v[31]) begin
      c = ref_crc(cell_in);
      cell_exp[51] = {6'b0, c[9:8]};
      cell_exp[52] = c[7:0];
    end
  endtask

  task automatic send_cell(input logic [31:0] v);
    bit bad_mark;
    bad_mark = 0;
    for (int i = 0; i < 53; i++) begin
      bit done;
      done = 0;
      while (!done) begin
        @(negedge clk);
        in_valid = 1'b1;
        in_sop   = (i == 0);
        in_data  = cell_in[i];
        if (i == 0) begin
          cmd_crc_en = v[31]; cmd_hdr_mod = v[30]; cmd_wr_pti = v[29];
          cmd_wr_vci = v[28]; cmd_pti = v[27:25]; cmd_vci = v[24:9];
        end else begin
          cmd_crc_en = ~v[31]; cmd_hdr_mod = ~v[30]; cmd_wr_pti = ~v[29];
          cmd_wr_vci = ~v[28]; cmd_pti = ~v[27:25]; cmd_vci = ~v[24:9];
        end
        rng = next_rng(rng);
        out_ready = v[0] ? rng[20] : 1'b1;
        #1;
        if (!(out_valid === 1'b1 && in_ready === out_ready)) bad_mark = 1;
        if (out_valid && out_ready) begin
          cell_out[i] = out_data;
          if (out_sop !== (i == 0) || out_eop !== (i == 52)) bad_mark = 1;
          done = 1;
        end
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_sop = 1'b0; out_ready = 1'b1;
    check_bit("R3 handshake/R1 markers", bad_mark, 1'b0);
  endtask

  task automatic judge(input logic [31:0] v);
    for (int i = 0; i < 53; i++) begin
      string r;
      if (i == 0 || i == 4)           r = "R7";
      else if (i < 4)                 r = !v[30] ? "R7" : (i == 3 ? "R6/R5" : "R5");
      else if (!v[31])                r = "R9";
      else if (v[0])                  r = "R10";
      else                            r = "R8";
      check(r, i, cell_out[i], cell_exp[i]);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    check_bit("R2 reset out_valid", out_valid, 1'b0);
    check_bit("R2 reset in_ready", in_ready, 1'b1);
    rst_n = 1'b1;

    for (int k = 0; k < 8; k++) begin
      logic [7:0] s;
      s = VEC[k][8:1];
      for (int j = 0; j < 53; j++) cell_in[j] = 8'((s * 13) + (j * 29) + (j * j)) ^ s;
      build_expect(VEC[k]);
      send_cell(VEC[k]);
      judge(VEC[k]);
    end

    // R2: idle octets without a start marker are dropped
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sop = 1'b0; in_data = 8'hA5; out_ready = 1'b0;
      #1;
      check_bit("R2 idle drop out_valid", out_valid, 1'b0);
      check_bit("R2 idle drop in_ready", in_ready, 1'b1);
    end
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b1;

    // R8: all-zero payload yields a zero code, header F5 end-to-end
    for (int j = 0; j < 53; j++) cell_in[j] = (j < 5) ? 8'(8'h40 + j) : 8'h00;
    build_expect({1'b1, 1'b1, 1'b1, 1'b0, 3'b101, 16'd0, 8'h00, 1'b1});
    check("R8 zero-code model", 52, cell_exp[52], 8'h00);
    send_cell({1'b1, 1'b1, 1'b1, 1'b0, 3'b101, 16'd0, 8'h00, 1'b1});
    judge({1'b1, 1'b1, 1'b1, 1'b0, 3'b101, 16'd0, 8'h00, 1'b1});

    // R4: a second cell right after, with a different command, is not affected by the previous one
    for (int j = 0; j < 53; j++) cell_in[j] = 8'hFF;
    build_expect({1'b0, 1'b1, 1'b0, 1'b1, 3'b000, 16'd3, 8'h00, 1'b0});
    send_cell({1'b0, 1'b1, 1'b0, 1'b1, 3'b000, 16'd3, 8'h00, 1'b0});
    judge({1'b0, 1'b1, 1'b0, 1'b1, 3'b000, 16'd3, 8'h00, 1'b0});
    check("R4 held command vci", 2, cell_out[2], 8'h00);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule